// File: doc/BRIEF.md
# Three-Port Priority Local Store Arbiter

This block owns a single-ported 256 KB local store and shares it among three requesters: a DMA port, a processor load/store port and an instruction-fetch port. The store can do only one read or one write per cycle, so the arbiter picks one winner each cycle by fixed priority. It steers that winner's line address, write data and byte enables into the storage array. Read data comes back on a shared bus one cycle later, marked by the winner's own valid pulse.

The requesters use different access sizes. Load/store always moves one 16-byte line. A fetch always reads eight consecutive lines. A DMA access is either a sub-line piece of 1, 2, 4 or 8 bytes, written through per-byte enables, or a whole number of lines from 16 to 128 bytes. Any transfer longer than one line goes out one line per granted cycle. A higher-priority port may take any cycle between those lines, and the interrupted transfer then carries on from the next line it has not yet moved.

Each requester raises `req` and keeps its request inputs steady until it has received a `gnt` for every line of the transfer. The storage is a behavioural array held inside the block. Each row of the array holds eight lines.

Top module: `ls_arbiter`

## Requirements
- R1: At most one port is granted in any cycle, so at most one of the three read-valid outputs is high in any cycle.
- R2: Priority is fixed: DMA beats load/store, and load/store beats fetch. A request that loses gets no grant in that cycle.
- R3: Addresses are byte addresses. The line index is address bits [17:4]. Bits [3:0] are ignored for line accesses, and bits above 17 are ignored, so addresses wrap modulo 0x40000.
- R4: A load/store access reads or writes exactly one full line. After a granted read, `ls_rvalid` is high in the next cycle and `rdata` holds the line.
- R5: A fetch reads eight lines, starting at the line of `ifu_addr` and counting upward. The line index wraps from 0x3FFF to 0x0000. There is one grant and one `ifu_rvalid` per line, in that order.
- R6: A DMA with `dma_bytes` of 1, 2, 4 or 8 writes only the byte lanes from `dma_addr[3:0]` up to `dma_addr[3:0]+dma_bytes-1`. Byte lane k is `dma_wdata[8k+7:8k]`. All other bytes of the line keep their old value.
- R7: A DMA with `dma_bytes` = 16·n (n from 1 to 8) moves n consecutive lines, starting at the line of `dma_addr`, with one grant per line. On a write, each line takes the `dma_wdata` present in its grant cycle. On a read, each line returns with one `dma_rvalid`.
- R8: A higher-priority request may take a cycle in the middle of a multi-line transfer. The transfer stalls during that cycle and then resumes at the first line it has not yet moved.
- R9: While reset is asserted, no grant and no read-valid is given. A transfer that was cut off by reset starts again from its first line.
- R10: `*_busy` is high exactly when that port is requesting and is not granted in the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_req | input | 1 | DMA request |
| dma_we | input | 1 | DMA write (1) or read (0) |
| dma_addr | input | 32 | DMA byte address, aligned to the transfer size |
| dma_bytes | input | 8 | DMA size in bytes: 1, 2, 4, 8 or 16·n with n from 1 to 8 |
| dma_wdata | input | 128 | DMA write data for the current line |
| dma_gnt | output | 1 | DMA line granted this cycle |
| dma_busy | output | 1 | DMA stalled this cycle |
| dma_rvalid | output | 1 | DMA read line on rdata |
| ls_req | input | 1 | Load/store request |
| ls_we | input | 1 | Load/store write (1) or read (0) |
| ls_addr | input | 32 | Load/store byte address |
| ls_wdata | input | 128 | Load/store write line |
| ls_gnt | output | 1 | Load/store granted this cycle |
| ls_busy | output | 1 | Load/store stalled this cycle |
| ls_rvalid | output | 1 | Load/store read line on rdata |
| ifu_req | input | 1 | Fetch request |
| ifu_addr | input | 32 | Fetch start byte address |
| ifu_gnt | output | 1 | Fetch line granted this cycle |
| ifu_busy | output | 1 | Fetch stalled this cycle |
| ifu_rvalid | output | 1 | Fetch line on rdata |
| rdata | output | 128 | Shared read data, valid with one rvalid |

## Verification
The block's only hidden state is the line-count register of each burst port and the array contents. A wrong burst counter therefore shows up on the ports as a wrong or misordered line on `rdata`. It also shows up as the wrong number of grants: a counter that fails to hold during a preemption skips a line, and one that fails to clear repeats a line or leaves an extra grant at the end of the burst. These faults appear within the same eight-line burst. Broken byte enables or lane placement show at the next read of that line, where neighbouring bytes come back changed.

// File: rtl/ls_arbiter.sv
module ls_arbiter #(
  parameter int LINE_BYTES = 16,
  parameter int BURST      = 8,
  parameter int ROWS       = 2048,
  parameter int AW         = 32
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 dma_req,
  input  logic                                 dma_we,
  input  logic [AW-1:0]                        dma_addr,
  input  logic [$clog2(LINE_BYTES*BURST):0]    dma_bytes,
  input  logic [LINE_BYTES*8-1:0]              dma_wdata,
  output logic                                 dma_gnt,
  output logic                                 dma_busy,
  output logic                                 dma_rvalid,
  input  logic                                 ls_req,
  input  logic                                 ls_we,
  input  logic [AW-1:0]                        ls_addr,
  input  logic [LINE_BYTES*8-1:0]              ls_wdata,
  output logic                                 ls_gnt,
  output logic                                 ls_busy,
  output logic                                 ls_rvalid,
  input  logic                                 ifu_req,
  input  logic [AW-1:0]                        ifu_addr,
  output logic                                 ifu_gnt,
  output logic                                 ifu_busy,
  output logic                                 ifu_rvalid,
  output logic [LINE_BYTES*8-1:0]              rdata
);
  localparam int LW    = LINE_BYTES * 8;
  localparam int OFFW  = $clog2(LINE_BYTES);
  localparam int SUBW  = $clog2(BURST);
  localparam int ROWW  = $clog2(ROWS);
  localparam int LIDXW = ROWW + SUBW;
  localparam int LENW  = $clog2(LINE_BYTES*BURST) + 1;
  localparam int NLW   = LENW - OFFW;
  localparam logic [SUBW-1:0] LAST_IFU = SUBW'(BURST - 1);

  logic [LW*BURST-1:0] mem [ROWS];

  logic [SUBW-1:0]  dma_beat, ifu_beat, dma_last;
  logic [NLW-1:0]   dma_nl;
  logic [2*LINE_BYTES-1:0] ones_w;
  logic [LINE_BYTES-1:0]   dma_be;

  logic [LIDXW-1:0]      sel_line;
  logic                  sel_we, sel_any;
  logic [LW-1:0]         sel_wd;
  logic [LINE_BYTES-1:0] sel_be;
  logic [ROWW-1:0]       sel_row;
  logic [SUBW-1:0]       sel_lane;

  assign dma_gnt = rst_n & dma_req;
  assign ls_gnt  = rst_n & ls_req & ~dma_req;
  assign ifu_gnt = rst_n & ifu_req & ~dma_req & ~ls_req;

  assign dma_busy = dma_req & ~dma_gnt;
  assign ls_busy  = ls_req & ~ls_gnt;
  assign ifu_busy = ifu_req & ~ifu_gnt;

  assign dma_nl   = dma_bytes[LENW-1:OFFW];
  assign dma_last = (dma_nl == '0) ? '0 : SUBW'(dma_nl - 1'b1);
  assign ones_w   = ({{(2*LINE_BYTES-1){1'b0}}, 1'b1} << dma_bytes) - 1'b1;
  assign dma_be   = (dma_nl == '0) ? (ones_w[LINE_BYTES-1:0] << dma_addr[OFFW-1:0]) : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_beat <= '0;
      ifu_beat <= '0;
    end else begin
      if (dma_gnt) dma_beat <= (dma_beat == dma_last) ? '0 : dma_beat + 1'b1;
      if (ifu_gnt) ifu_beat <= (ifu_beat == LAST_IFU) ? '0 : ifu_beat + 1'b1;
    end
  end

  always_comb begin
    sel_line = '0;
    sel_we   = 1'b0;
    sel_wd   = '0;
    sel_be   = '0;
    if (dma_gnt) begin
      sel_line = dma_addr[OFFW +: LIDXW] + LIDXW'(dma_beat);
      sel_we   = dma_we;
      sel_wd   = dma_wdata;
      sel_be   = dma_be;
    end else if (ls_gnt) begin
      sel_line = ls_addr[OFFW +: LIDXW];
      sel_we   = ls_we;
      sel_wd   = ls_wdata;
      sel_be   = '1;
    end else if (ifu_gnt) begin
      sel_line = ifu_addr[OFFW +: LIDXW] + LIDXW'(ifu_beat);
    end
  end

  assign sel_any  = dma_gnt | ls_gnt | ifu_gnt;
  assign sel_row  = sel_line[LIDXW-1:SUBW];
  assign sel_lane = sel_line[SUBW-1:0];

  always_ff @(posedge clk) begin
    if (sel_any && sel_we) begin
      for (int b = 0; b < LINE_BYTES; b++)
        if (sel_be[b]) mem[sel_row][(int'(sel_lane)*LINE_BYTES + b)*8 +: 8] <= sel_wd[b*8 +: 8];
    end
    if (sel_any && !sel_we) rdata <= mem[sel_row][int'(sel_lane)*LW +: LW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_rvalid <= 1'b0;
      ls_rvalid  <= 1'b0;
      ifu_rvalid <= 1'b0;
    end else begin
      dma_rvalid <= dma_gnt & ~dma_we;
      ls_rvalid  <= ls_gnt & ~ls_we;
      ifu_rvalid <= ifu_gnt;
    end
  end

  p_single_return_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dma_rvalid, ls_rvalid, ifu_rvalid}));

  p_dma_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> !ls_gnt && !ifu_gnt);

  p_ls_return_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ls_gnt && !ls_we |=> ls_rvalid);

  p_fetch_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ifu_gnt && ifu_beat != LAST_IFU |=> ifu_beat == $past(ifu_beat) + 1'b1);

  p_dma_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_gnt && dma_beat == dma_last |=> dma_beat == '0);

  p_fetch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ifu_req && !ifu_gnt |=> $stable(ifu_beat));

  p_dma_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_gnt |=> $stable(dma_beat));
endmodule

// File: tb/sim_ls_arbiter.sv
`timescale 1ns/1ps
module sim_ls_arbiter;
  localparam real CYC = 4.0;
  logic clk = 1'b0, rst_n = 1'b0;
  logic dma_req = 0, dma_we = 0, ls_req = 0, ls_we = 0, ifu_req = 0;
  logic [31:0] dma_addr = 0, ls_addr = 0, ifu_addr = 0;
  logic [7:0] dma_bytes = 0;
  logic [127:0] dma_wdata = 0, ls_wdata = 0;
  logic dma_gnt, dma_busy, dma_rvalid, ls_gnt, ls_busy, ls_rvalid, ifu_gnt, ifu_busy, ifu_rvalid;
  logic [127:0] rdata;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CYC/2) clk = ~clk;

  ls_arbiter u0 (.clk(clk), .rst_n(rst_n),
    .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr), .dma_bytes(dma_bytes), .dma_wdata(dma_wdata),
    .dma_gnt(dma_gnt), .dma_busy(dma_busy), .dma_rvalid(dma_rvalid),
    .ls_req(ls_req), .ls_we(ls_we), .ls_addr(ls_addr), .ls_wdata(ls_wdata),
    .ls_gnt(ls_gnt), .ls_busy(ls_busy), .ls_rvalid(ls_rvalid),
    .ifu_req(ifu_req), .ifu_addr(ifu_addr),
    .ifu_gnt(ifu_gnt), .ifu_busy(ifu_busy), .ifu_rvalid(ifu_rvalid), .rdata(rdata));

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] pat(input int line);
    return {4{32'hC0DE0000 | line}};
  endfunction

  task automatic ls_op(input bit we, input logic [31:0] a, input logic [127:0] wd, output logic [127:0] rd);
    @(negedge clk);
    ls_req = 1; ls_we = we; ls_addr = a; ls_wdata = wd;
    #0.5;
    chk(ls_gnt, "R4 ls grant", 128'(ls_gnt), 128'd1);
    @(negedge clk);
    ls_req = 0;
    if (!we) chk(ls_rvalid, "R4 ls rvalid", 128'(ls_rvalid), 128'd1);
    rd = rdata;
  endtask

  task automatic dma_one(input bit we, input logic [31:0] a, input logic [7:0] n, input logic [127:0] wd, output logic [127:0] rd);
    @(negedge clk);
    dma_req = 1; dma_we = we; dma_addr = a; dma_bytes = n; dma_wdata = wd;
    #0.5;
    chk(dma_gnt, "R6 dma grant", 128'(dma_gnt), 128'd1);
    @(negedge clk);
    dma_req = 0;
    if (!we) chk(dma_rvalid, "R7 dma rvalid", 128'(dma_rvalid), 128'd1);
    rd = rdata;
  endtask

  task automatic fetch(input logic [31:0] a, input int pre_cyc, input int stop_after);
    int ng = 0, nrv = 0, base;
    base = int'(a[17:4]);
    @(negedge clk);
    ifu_req = 1; ifu_addr = a;
    for (int c = 0; c < 40 && ng < stop_after; c++) begin
      if (ifu_rvalid) begin
        chk(rdata == pat((base + nrv) & 16'h3FFF), "R5 fetch line order", rdata, pat((base + nrv) & 16'h3FFF));
        nrv++;
      end
      if (c == pre_cyc + 1) chk(ls_rvalid && rdata == pat(2), "R8 preempting read data", rdata, pat(2));
      ls_req = (c == pre_cyc); ls_we = 0; ls_addr = 32'h20;
      #0.5;
      if (c == pre_cyc) chk(ls_gnt && !ifu_gnt && ifu_busy, "R8 fetch yields", {ls_gnt, ifu_gnt, ifu_busy}, 3'b101);
      if (ifu_gnt) ng++;
      @(negedge clk);
    end
    ls_req = 0;
    if (stop_after == 8) begin
      if (ifu_rvalid) begin
        chk(rdata == pat((base + nrv) & 16'h3FFF), "R5 fetch last line", rdata, pat((base + nrv) & 16'h3FFF));
        nrv++;
      end
      ifu_req = 0;
      chk(nrv == 8, "R5 fetch line count", 128'(nrv), 128'd8);
      #0.5;
      chk(!ifu_gnt, "R5 no grant after burst", 128'(ifu_gnt), 128'd0);
    end
  endtask

  typedef struct packed {
    logic [1:0]   op;
    logic [31:0]  addr;
    logic [7:0]   nb;
    logic [127:0] wd;
    logic [127:0] exp;
  } vec_t;

  localparam logic [127:0] LA = 128'h00112233_44556677_8899AABB_CCDDEEFF;
  localparam logic [127:0] LB = 128'hFFEEDDCC_BBAA9988_77665544_33221100;
  localparam logic [127:0] X3 = 128'hDEADBEEF_44556677_88995ABB_1234EEFF;
  localparam logic [127:0] LY = 128'h01020304_05060708_77665544_33221100;
  localparam vec_t TAB [10] = '{
    '{2'd0, 32'h00010, 8'd16, LA, LA},
    '{2'd3, 32'h0001F, 8'd16, 128'd0, LA},
    '{2'd0, 32'h40020, 8'd16, LB, LB},
    '{2'd3, 32'h00020, 8'd16, 128'd0, LB},
    '{2'd1, 32'h00015, 8'd1, 128'h5A << 40, 128'h00112233_44556677_88995ABB_CCDDEEFF},
    '{2'd1, 32'h0001C, 8'd4, 128'hDEADBEEF << 96, 128'hDEADBEEF_44556677_88995ABB_CCDDEEFF},
    '{2'd1, 32'h00012, 8'd2, 128'h1234 << 16, X3},
    '{2'd1, 32'h00028, 8'd8, 128'h01020304_05060708 << 64, LY},
    '{2'd2, 32'h00020, 8'd16, 128'd0, LY},
    '{2'd3, 32'hFFFC0010, 8'd16, 128'd0, X3}
  };

  initial begin
    #(CYC * 150000);
    chk(0, "watchdog", 0, 0);
    if (!finished) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] rd;
    ifu_req = 1;
    repeat (3) @(negedge clk);
    chk(!ifu_gnt && !ifu_rvalid && !ls_rvalid && !dma_rvalid, "R9 quiet in reset", {ifu_gnt, ifu_rvalid}, 0);
    ifu_req = 0;
    rst_n = 1;

    foreach (TAB[i]) begin
      case (TAB[i].op)
        2'd0: begin
          ls_op(1, TAB[i].addr, TAB[i].wd, rd);
          ls_op(0, TAB[i].addr, 0, rd);
          chk(rd == TAB[i].exp, "R3 R4 line write/read", rd, TAB[i].exp);
        end
        2'd1: begin
          dma_one(1, TAB[i].addr, TAB[i].nb, TAB[i].wd, rd);
          ls_op(0, TAB[i].addr, 0, rd);
          chk(rd == TAB[i].exp, "R6 sub-line merge", rd, TAB[i].exp);
        end
        2'd2: begin
          dma_one(0, TAB[i].addr, TAB[i].nb, 0, rd);
          chk(rd == TAB[i].exp, "R7 dma single line read", rd, TAB[i].exp);
        end
        default: begin
          ls_op(0, TAB[i].addr, 0, rd);
          chk(rd == TAB[i].exp, "R3 address decode", rd, TAB[i].exp);
        end
      endcase
    end

    // R2 R10: all three at once
    @(negedge clk);
    dma_req = 1; dma_we = 1; dma_addr = 32'h30; dma_bytes = 1; dma_wdata = 128'h77;
    ls_req = 1; ls_we = 0; ls_addr = 32'h10;
    ifu_req = 1; ifu_addr = 32'h0;
    #0.5;
    chk(dma_gnt && !ls_gnt && !ifu_gnt, "R2 dma wins", {dma_gnt, ls_gnt, ifu_gnt}, 3'b100);
    chk(ls_busy && ifu_busy && !dma_busy, "R10 busy flags", {dma_busy, ls_busy, ifu_busy}, 3'b011);
    @(negedge clk);
    dma_req = 0;
    #0.5;
    chk(ls_gnt && !ifu_gnt && ifu_busy && !ls_busy, "R2 ls over fetch", {ls_gnt, ifu_gnt, ifu_busy}, 3'b101);
    @(negedge clk);
    chk(ls_rvalid && rdata == X3, "R4 ls data after contention", rdata, X3);
    ls_req = 0;
    #0.5;
    chk(ifu_gnt && !ifu_busy, "R2 fetch granted when alone", 128'(ifu_gnt), 128'd1);
    repeat (8) @(negedge clk);
    ifu_req = 0;

    // R7: four-line DMA write then two-line read
    begin
      int k = 0, nrv = 0;
      @(negedge clk);
      dma_req = 1; dma_we = 1; dma_addr = 32'h100; dma_bytes = 64;
      for (int c = 0; c < 12 && k < 4; c++) begin
        dma_wdata = {4{32'hB0000000 | k}};
        #0.5;
        if (dma_gnt) k++;
        @(negedge clk);
      end
      dma_req = 0;
      chk(k == 4, "R7 dma line grants", 128'(k), 128'd4);
      for (int l = 0; l < 4; l++) begin
        ls_op(0, 32'h100 + 32'(l * 16), 0, rd);
        chk(rd == {4{32'hB0000000 | l}}, "R7 dma burst line data", rd, {4{32'hB0000000 | l}});
      end
      @(negedge clk);
      dma_req = 1; dma_we = 0; dma_addr = 32'h100; dma_bytes = 32;
      for (int c = 0; c < 4; c++) begin
        if (c == 2) dma_req = 0;
        @(negedge clk);
        if (dma_rvalid) begin
          chk(rdata == {4{32'hB0000000 | nrv}}, "R7 dma read line", rdata, {4{32'hB0000000 | nrv}});
          nrv++;
        end
      end
      chk(nrv == 2, "R7 dma read count", 128'(nrv), 128'd2);
    end

    // preload wrap region
    for (int i = 0; i < 8; i++) ls_op(1, 32'((16'h3FFC + i) & 16'h3FFF) << 4, pat((16'h3FFC + i) & 16'h3FFF), rd);

    fetch(32'h3FFC5, 2, 8);

    // R9: reset mid-burst restarts from line 0 of the burst
    fetch(32'h3FFC0, -5, 3);
    rst_n = 0; ifu_req = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    fetch(32'h3FFC0, -5, 8);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule